// File: doc/BRIEF.md
# Eight-Function ALU with Condition Flags

This block is a combinational arithmetic logic unit for two equal-width operands. A 3-bit opcode picks one of eight functions: bitwise OR, bitwise AND, addition, subtraction, logical left shift, logical right shift, arithmetic right shift, and a signed less-than test. The result appears on the output in the same cycle, with no register anywhere on the path. The surrounding datapath registers the result if it needs to.

The block also produces a five-bit condition vector. That vector reports operand equality, signed overflow, unsigned overflow, a zero result and a negative result. Every flag is derived fresh from the current inputs, so no flag carries over from one operation to the next. The two overflow flags are forced low for every opcode except add and subtract. Subtraction runs through the same adder as addition: it feeds the inverted Y operand and a carry-in of one.

Top module: `eightop_alu`

## Requirements
- R1: Opcode 000 drives the result with X OR Y, and opcode 001 drives it with X AND Y.
- R2: Opcode 010 drives the result with the low 8 bits of X+Y. Flag bit 2 (CF) equals the carry out of bit 7. Flag bit 1 (OF) is 1 when X and Y have the same sign and the result's sign differs from it.
- R3: Opcode 011 drives the result with X−Y modulo 256. CF is 1 exactly when X is below Y as unsigned values, which marks a borrow. OF is 1 in two cases: X is non-negative, Y is negative and the result is negative; or X is negative, Y is non-negative and the result is non-negative.
- R4: Opcode 100 shifts X left by the shift count and fills the vacated low bits with zeros.
- R5: Opcode 101 shifts X right and fills the vacated bits with zeros. Opcode 110 shifts X right and fills the vacated bits with copies of X bit 7.
- R6: The shift count for opcodes 100, 101 and 110 is Y[2:0]. Y[7:3] has no effect on the result or on any flag other than EQ.
- R7: Opcode 111 gives 8'h01 when X is below Y as signed two's complement values, and 8'h00 otherwise.
- R8: Flag bit 0 (EQ) is 1 exactly when X equals Y, for every opcode.
- R9: Flag bit 3 (ZF) is 1 exactly when the 8-bit result is zero. Flag bit 4 (SF) equals result bit 7. Both hold for every opcode.
- R10: OF (bit 1) and CF (bit 2) are 0 for every opcode other than 010 and 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | 8 | First operand X |
| y_i | input | 8 | Second operand Y; its low 3 bits are the shift count |
| op_i | input | 3 | Function select |
| res_o | output | 8 | Selected function result |
| flags_o | output | 5 | {SF, ZF, CF, OF, EQ}, from bit 4 down to bit 0 |

## Verification
The bench builds the block with its default 8-bit operand width. At that width every X value can be swept against a strided range of Y values under all eight opcodes, and each result is compared with a reference model written independently from the requirements. A directed vector table adds the cases the sweep could miss. These are the corners of signed overflow in both directions through the shared adder, a borrow with a positive result, and shift counts whose ignored upper Y bits are non-zero. It also covers the sign-fill difference between the two right shifts.

// File: rtl/eightop_alu_pkg.sv
package eightop_alu_pkg;

    typedef enum logic [2:0] {
        OP_OR  = 3'b000,
        OP_AND = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b011,
        OP_SHL = 3'b100,
        OP_SHR = 3'b101,
        OP_SAR = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    localparam int FLG_EQ    = 0;
    localparam int FLG_OF    = 1;
    localparam int FLG_CF    = 2;
    localparam int FLG_ZF    = 3;
    localparam int FLG_SF    = 4;
    localparam int NUM_FLAGS = 5;

endpackage

// File: rtl/alu_addsub.sv
// Shared adder: subtraction is a + ~b + 1 on the same carry chain.
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff  = b_i ^ {W{sub_i}};
        wide   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
        sum_o  = wide[W-1:0];
        cout_o = wide[W];
        // operands seen by the adder agree in sign, sum disagrees
        ovf_o  = (a_i[W-1] == b_eff[W-1]) && (wide[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu_shifter.sv
// Logarithmic barrel shifter; one stage per bit of the shift count.
module alu_shifter #(
    parameter int W = 8,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  a_i,
    input  logic [SW-1:0] amt_i,
    input  logic          arith_i,
    output logic [W-1:0]  left_o,
    output logic [W-1:0]  right_o
);
    logic         fill;
    logic [W-1:0] l_stg [0:SW];
    logic [W-1:0] r_stg [0:SW];

    assign fill     = arith_i & a_i[W-1];
    assign l_stg[0] = a_i;
    assign r_stg[0] = a_i;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign l_stg[s+1] = amt_i[s] ? {l_stg[s][W-1-SH:0], {SH{1'b0}}} : l_stg[s];
        assign r_stg[s+1] = amt_i[s] ? {{SH{fill}}, r_stg[s][W-1:SH]}  : r_stg[s];
    end

    assign left_o  = l_stg[SW];
    assign right_o = r_stg[SW];
endmodule

// File: rtl/alu_flags.sv
// Condition vector: every bit rebuilt from current inputs.
module alu_flags
    import eightop_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]         x_i,
    input  logic [W-1:0]         y_i,
    input  logic [W-1:0]         res_i,
    input  logic                 arith_i,
    input  logic                 sub_i,
    input  logic                 cout_i,
    input  logic                 ovf_i,
    output logic [NUM_FLAGS-1:0] flags_o
);
    always_comb begin
        flags_o         = '0;
        flags_o[FLG_EQ] = (x_i == y_i);
        flags_o[FLG_OF] = arith_i & ovf_i;
        // borrow is the inverse of the carry when subtracting
        flags_o[FLG_CF] = arith_i & (cout_i ^ sub_i);
        flags_o[FLG_ZF] = (res_i == '0);
        flags_o[FLG_SF] = res_i[W-1];
    end
endmodule

// File: rtl/eightop_alu.sv
module eightop_alu
    import eightop_alu_pkg::*;
#(
    parameter int W = 8,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]         x_i,
    input  logic [W-1:0]         y_i,
    input  logic [2:0]           op_i,
    output logic [W-1:0]         res_o,
    output logic [NUM_FLAGS-1:0] flags_o
);
    typedef struct packed {
        logic         is_sub;
        logic         is_arith;
        logic         is_sar;
        logic [W-1:0] res;
    } alu_sel_t;

    alu_op_e      op;
    alu_sel_t     sel_d;
    logic [W-1:0] sum;
    logic         cout;
    logic         ovf;
    logic [W-1:0] shl;
    logic [W-1:0] shr;

    assign op = alu_op_e'(op_i);

    alu_addsub #(.W(W)) u_addsub (
        .a_i    (x_i),
        .b_i    (y_i),
        .sub_i  (sel_d.is_sub),
        .sum_o  (sum),
        .cout_o (cout),
        .ovf_o  (ovf)
    );

    alu_shifter #(.W(W)) u_shift (
        .a_i     (x_i),
        .amt_i   (y_i[SW-1:0]),
        .arith_i (sel_d.is_sar),
        .left_o  (shl),
        .right_o (shr)
    );

    always_comb begin
        sel_d          = '0;
        sel_d.is_sub   = (op == OP_SUB);
        sel_d.is_arith = (op == OP_ADD) || (op == OP_SUB);
        sel_d.is_sar   = (op == OP_SAR);
        unique case (op)
            OP_OR:  sel_d.res = x_i | y_i;
            OP_AND: sel_d.res = x_i & y_i;
            OP_ADD,
            OP_SUB: sel_d.res = sum;
            OP_SHL: sel_d.res = shl;
            OP_SHR,
            OP_SAR: sel_d.res = shr;
            OP_SLT: sel_d.res = {{(W-1){1'b0}}, ($signed(x_i) < $signed(y_i))};
            default: sel_d.res = '0;
        endcase
    end

    assign res_o = sel_d.res;

    alu_flags #(.W(W)) u_flags (
        .x_i     (x_i),
        .y_i     (y_i),
        .res_i   (sel_d.res),
        .arith_i (sel_d.is_arith),
        .sub_i   (sel_d.is_sub),
        .cout_i  (cout),
        .ovf_i   (ovf),
        .flags_o (flags_o)
    );
endmodule

// File: rtl/eightop_alu_chk.sv
module eightop_alu_chk
    import eightop_alu_pkg::*;
#(
    parameter int W = 8
) (
    input logic [W-1:0]         x_i,
    input logic [W-1:0]         y_i,
    input logic [2:0]           op_i,
    input logic [W-1:0]         res_o,
    input logic [NUM_FLAGS-1:0] flags_o
);
    logic [W-1:0] add_ref;
    logic         not_arith;

    always_comb begin
        add_ref   = x_i + y_i;
        not_arith = (op_i != OP_ADD) && (op_i != OP_SUB);

        // R1
        or_res_chk: assert (op_i != OP_OR || res_o == (x_i | y_i));
        // R2
        add_res_chk: assert (op_i != OP_ADD || res_o == add_ref);
        // R3
        sub_borrow_chk: assert (op_i != OP_SUB || flags_o[FLG_CF] == (x_i < y_i));
        // R7
        slt_shape_chk: assert (op_i != OP_SLT || res_o[W-1:1] == '0);
        // R8
        eq_flag_chk: assert (flags_o[FLG_EQ] == (x_i == y_i));
        // R9
        zero_flag_chk: assert (flags_o[FLG_ZF] == (res_o == '0));
        // R9
        sign_flag_chk: assert (flags_o[FLG_SF] == res_o[W-1]);
        // R10
        gated_ovf_chk: assert (!not_arith || (flags_o[FLG_OF] == 1'b0 && flags_o[FLG_CF] == 1'b0));
    end
endmodule

bind eightop_alu eightop_alu_chk #(.W(W)) u_chk (
    .x_i     (x_i),
    .y_i     (y_i),
    .op_i    (op_i),
    .res_o   (res_o),
    .flags_o (flags_o)
);

// File: tb/eightop_alu_bench.sv
module eightop_alu_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] x, y;
    logic [2:0] op;
    logic [7:0] res;
    logic [4:0] flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    eightop_alu u_eightop_alu (
        .x_i     (x),
        .y_i     (y),
        .op_i    (op),
        .res_o   (res),
        .flags_o (flags)
    );

    // {op, x, y, result, {SF,ZF,CF,OF,EQ}}
    localparam int NV = 19;
    localparam logic [31:0] VEC [NV] = '{
        {3'd0, 8'h0F, 8'hF0, 8'hFF, 5'b10000},  // R1 OR
        {3'd1, 8'h0F, 8'hF0, 8'h00, 5'b01000},  // R1 AND, zero result
        {3'd2, 8'h41, 8'h41, 8'h82, 5'b10011},  // R2 signed overflow, equal operands
        {3'd3, 8'h00, 8'h01, 8'hFF, 5'b10100},  // R3 borrow without OF
        {3'd2, 8'hFF, 8'h01, 8'h00, 5'b01100},  // R2 carry out, zero
        {3'd2, 8'h80, 8'h80, 8'h00, 5'b01111},  // R2 CF and OF together, EQ
        {3'd3, 8'h03, 8'hFA, 8'h09, 5'b00100},  // R3 pos - neg, no OF
        {3'd3, 8'h7F, 8'hFF, 8'h80, 5'b10110},  // R3 pos - neg -> neg, OF
        {3'd3, 8'h80, 8'h01, 8'h7F, 5'b00010},  // R3 neg - pos -> pos, OF
        {3'd3, 8'h05, 8'h05, 8'h00, 5'b01001},  // R3 equal operands
        {3'd4, 8'h54, 8'h54, 8'h40, 5'b00001},  // R4 R6 count = 4 from y
        {3'd4, 8'hB8, 8'h01, 8'h70, 5'b00000},  // R4
        {3'd5, 8'hB9, 8'h01, 8'h5C, 5'b00000},  // R5 zero fill
        {3'd6, 8'hB9, 8'hF9, 8'hDC, 5'b10000},  // R5 R6 sign fill, upper y ignored
        {3'd6, 8'h41, 8'h01, 8'h20, 5'b00000},  // R5 positive sign fill
        {3'd5, 8'hFF, 8'hFF, 8'h01, 5'b00001},  // R6 count 7
        {3'd7, 8'h80, 8'h01, 8'h01, 5'b00000},  // R7 negative < positive
        {3'd7, 8'h01, 8'h80, 8'h00, 5'b01000},  // R7 positive not < negative
        {3'd7, 8'h05, 8'h05, 8'h00, 5'b01001}   // R7 equal
    };

    function automatic string op_tag(input logic [2:0] o);
        case (o)
            3'd0, 3'd1: return "R1";
            3'd2:       return "R2";
            3'd3:       return "R3";
            3'd4:       return "R4 R6";
            3'd5, 3'd6: return "R5 R6";
            default:    return "R7";
        endcase
    endfunction

    // Reference model written from the requirements.
    function automatic logic [12:0] ref_eval(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b);
        int          ua, ub, sa, sb, t;
        logic [7:0]  r;
        logic signed [7:0] sx;
        logic        cf, of;
        ua = int'(a); ub = int'(b);
        sa = (ua > 127) ? ua - 256 : ua;
        sb = (ub > 127) ? ub - 256 : ub;
        cf = 1'b0; of = 1'b0;
        case (o)
            3'd0: r = a | b;
            3'd1: r = a & b;
            3'd2: begin
                t = ua + ub; r = t[7:0]; cf = (t > 255);
                t = sa + sb; of = (t > 127) || (t < -128);
            end
            3'd3: begin
                t = ua - ub; r = t[7:0]; cf = (ua < ub);
                t = sa - sb; of = (t > 127) || (t < -128);
            end
            3'd4: r = a << b[2:0];
            3'd5: r = a >> b[2:0];
            3'd6: begin sx = a; r = 8'(sx >>> b[2:0]); end
            default: r = (sa < sb) ? 8'h01 : 8'h00;
        endcase
        return {r, r[7], (r == 8'h00), cf, of, (a == b)};
    endfunction

    task automatic apply_check(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
                               input logic [7:0] er, input logic [4:0] ef);
        @(posedge clk);
        op = o; x = a; y = b;
        @(negedge clk);
        checks++;
        if (res !== er) begin
            fails++;
            $display("FAIL %s op=%0d x=%h y=%h result actual=%h expected=%h", op_tag(o), o, a, b, res, er);
        end
        checks++;
        if (flags !== ef) begin
            fails++;
            $display("FAIL R8 R9 R10 %s op=%0d x=%h y=%h flags actual=%b expected=%b",
                     op_tag(o), o, a, b, flags, ef);
        end
    endtask

    initial begin
        logic [12:0] e;
        op = 3'd0; x = 8'h00; y = 8'h00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: OR of zeros gives zero with ZF and EQ (R9 R8)
        @(negedge clk);
        checks++;
        if (res !== 8'h00 || flags !== 5'b01001) begin
            fails++;
            $display("FAIL R8 R9 idle actual=%h/%b expected=00/01001", res, flags);
        end
        // Directed table
        for (int i = 0; i < NV; i++)
            apply_check(VEC[i][31:29], VEC[i][28:21], VEC[i][20:13], VEC[i][12:5], VEC[i][4:0]);
        // Same shift with differing upper y bits gives the same result (R6)
        for (int hi = 0; hi < 32; hi += 9)
            apply_check(3'd6, 8'h96, {hi[4:0], 3'd3}, 8'hF2, 5'b10000);
        // Non-arith opcodes never raise OF or CF on overflow-prone operands (R10)
        for (int o = 0; o < 8; o++)
            if (o != 2 && o != 3) begin
                e = ref_eval(3'(o), 8'h80, 8'h80);
                apply_check(3'(o), 8'h80, 8'h80, e[12:5], e[4:0]);
            end
        // Sweep all opcodes, every x, y stepped by 5
        for (int o = 0; o < 8; o++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 5) begin
                    e = ref_eval(3'(o), 8'(a), 8'(b));
                    apply_check(3'(o), 8'(a), 8'(b), e[12:5], e[4:0]);
                end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000 && !done) begin
                fails++;
                checks++;
                $display("FAIL watchdog expired actual=%0d cycles expected<190000", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

endmodule